// File: doc/BRIEF.md
# Shared 64-bit Up-Counting Timer

This block is a single 64-bit counter that counts upward and is shared by every agent on a small 32-bit register bus. Software reaches the count as two 32-bit words. A control word sets the count running, picks a clock divider, and turns on a comparator, its interrupt and its self-rearming step. While the counter runs it advances once every (divider+1) clocks. Writing zero to the control word halts it, and the count keeps its value.

The comparator watches for the count to equal a 64-bit compare value. On a match it sets a sticky event flag. Software clears the flag by writing one to it. When self-rearming is on, the compare value moves forward by a programmable 32-bit step on each match, so a periodic event needs no further software work.

Reads take one cycle. Reading the low count word also takes a copy of the high word, and a later read of the high word returns that copy. Software that reads low and then high therefore always gets one consistent 64-bit value.

Top module: `gtimer64`

## Requirements
- R1: After synchronous reset every register reads 0 and `irq_out` is 0.
- R2: With control bit 0 set, the count rises by exactly 1 on every (P+1)th clock, where P is control bits [15:8]. After the enable takes effect, the first increment lands on clock P+1.
- R3: Writing 0 to the control word (offset 0x08) stops counting. The count keeps its last value and is not cleared.
- R4: Writes to offsets 0x00 and 0x04 load the low and high count words. A load has priority over an increment in the same cycle. An increment carries from the low word into the high word.
- R5: `rd_data` is valid the cycle after `bus_rd` is asserted. A read of 0x00 returns the current low word and captures the high word. A read of 0x04 returns that captured value, not the live high word.
- R6: When control bit 1 is set and the count equals the compare value (low word at 0x10, high word at 0x14), the event flag (bit 0 of 0x0C) is set on the next clock. With bit 1 clear, or with no match, the flag is not set.
- R7: When control bit 3 is set, each match adds the step value at 0x18 to the 64-bit compare value in the same cycle that the flag is set.
- R8: Writing 1 to bit 0 of 0x0C clears the flag, and writing 0 there has no effect. If a match is present in the same cycle as the clear, the flag stays set.
- R9: `irq_out` is high exactly when the event flag is set and control bit 2 is set.
- R10: Control reads return only bits 0..3 and the divider field [15:8], with all other bits 0. Compare and step words read back as written. Unmapped offsets and misaligned addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (5) | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| rd_data | output | DATA_W (32) | Registered read data, valid one cycle after `bus_rd` |
| irq_out | output | 1 | Event interrupt (flag AND enable) |

## Verification
The counting rate is tested with the divider at 0 and at 3, running for windows of known length. The resulting counts show whether an increment lands on the correct edge or one edge off. A load of all-ones in the low word followed by a single increment tests the carry into the high word. Loading the high word between the low and high reads tests whether the high-word read uses the captured copy or the live value.

The comparator is tested four ways: with a match, with the compare enable off, with the high words different, and with a clear issued while the match is still present. These cases separate a level match from a missed one and show which of set and clear has priority. A match with self-rearming on tests that the compare value moves by exactly the step value, one time only.

// File: rtl/ft64_pkg.sv
package ft64_pkg;
  // word indices (byte offset >> 2); software depends on these positions
  localparam int IDX_CNT_LO = 0;
  localparam int IDX_CNT_HI = 1;
  localparam int IDX_CTRL   = 2;
  localparam int IDX_STAT   = 3;
  localparam int IDX_CMP_LO = 4;
  localparam int IDX_CMP_HI = 5;
  localparam int IDX_STEP   = 6;

  // control word bit positions
  localparam int CB_RUN     = 0;
  localparam int CB_CMP     = 1;
  localparam int CB_IRQ     = 2;
  localparam int CB_AUTO    = 3;
  localparam int CB_DIV_LSB = 8;
endpackage

// File: rtl/ft64_prescale.sv
module ft64_prescale #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] phase;

  // >= keeps the divider safe if div shrinks while running
  assign tick = run && (phase >= div);

  always_ff @(posedge clk) begin
    if (rst || !run) phase <= '0;
    else if (phase >= div) phase <= '0;
    else phase <= phase + DIV_W'(1);
  end
endmodule

// File: rtl/ft64_counter.sv
module ft64_counter #(
  parameter int DATA_W = 32,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  count
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (wr_lo || wr_hi) begin
      if (wr_lo) count[DATA_W-1:0]     <= wdata;
      if (wr_hi) count[CNT_W-1:DATA_W] <= wdata;
    end else if (tick) count <= count + CNT_W'(1);
  end

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_lo && !wr_hi) |=> count == $past(count) + CNT_W'(1));

  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_lo && !wr_hi) |=> $stable(count));
endmodule

// File: rtl/ft64_compare.sv
module ft64_compare #(
  parameter int DATA_W = 32,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  count,
  input  logic              cmp_on,
  input  logic              auto_on,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_step,
  input  logic              clr,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  cmp_val,
  output logic [DATA_W-1:0] step_val,
  output logic              flag
);
  logic hit;
  assign hit = cmp_on && (count == cmp_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_val  <= '0;
      step_val <= '0;
      flag     <= 1'b0;
    end else begin
      if (hit) flag <= 1'b1;
      else if (clr) flag <= 1'b0;

      if (wr_lo || wr_hi) begin
        if (wr_lo) cmp_val[DATA_W-1:0]     <= wdata;
        if (wr_hi) cmp_val[CNT_W-1:DATA_W] <= wdata;
      end else if (hit && auto_on) begin
        cmp_val <= cmp_val + {{DATA_W{1'b0}}, step_val};
      end

      if (wr_step) step_val <= wdata;
    end
  end

  // R6
  match_set_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_on && count == cmp_val) |=> flag);

  // R7
  auto_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_on && auto_on && count == cmp_val && !wr_lo && !wr_hi)
    |=> cmp_val == $past(cmp_val) + {{DATA_W{1'b0}}, $past(step_val)});

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !(cmp_on && count == cmp_val)) |=> !flag);
endmodule

// File: rtl/gtimer64.sv
module gtimer64
  import ft64_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_out
);
  localparam int CNT_W  = 2 * DATA_W;
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic [6:0]        sel;
  logic              run_q, cmp_q, ie_q, auto_q;
  logic [DIV_W-1:0]  div_q;
  logic              tick;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  cmp_val;
  logic [DATA_W-1:0] step_val;
  logic              flag;
  logic [DATA_W-1:0] hi_snap;
  logic [DATA_W-1:0] ctrl_view;
  logic [DATA_W-1:0] rd_mux;

  assign word    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  for (genvar g = 0; g < 7; g++) begin : g_sel
    assign sel[g] = aligned && (word == WORD_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0; cmp_q <= 1'b0; ie_q <= 1'b0; auto_q <= 1'b0;
      div_q <= '0;
    end else if (bus_we && sel[IDX_CTRL]) begin
      run_q  <= bus_wdata[CB_RUN];
      cmp_q  <= bus_wdata[CB_CMP];
      ie_q   <= bus_wdata[CB_IRQ];
      auto_q <= bus_wdata[CB_AUTO];
      div_q  <= bus_wdata[CB_DIV_LSB +: DIV_W];
    end
  end

  ft64_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .run(run_q), .div(div_q), .tick(tick)
  );

  ft64_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick),
    .wr_lo(bus_we && sel[IDX_CNT_LO]), .wr_hi(bus_we && sel[IDX_CNT_HI]),
    .wdata(bus_wdata), .count(count)
  );

  ft64_compare #(.DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst(rst), .count(count), .cmp_on(cmp_q), .auto_on(auto_q),
    .wr_lo(bus_we && sel[IDX_CMP_LO]), .wr_hi(bus_we && sel[IDX_CMP_HI]),
    .wr_step(bus_we && sel[IDX_STEP]),
    .clr(bus_we && sel[IDX_STAT] && bus_wdata[0]),
    .wdata(bus_wdata), .cmp_val(cmp_val), .step_val(step_val), .flag(flag)
  );

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CB_RUN]  = run_q;
    ctrl_view[CB_CMP]  = cmp_q;
    ctrl_view[CB_IRQ]  = ie_q;
    ctrl_view[CB_AUTO] = auto_q;
    ctrl_view[CB_DIV_LSB +: DIV_W] = div_q;
  end

  always_comb begin
    rd_mux = '0;
    if (sel[IDX_CNT_LO]) rd_mux = count[DATA_W-1:0];
    if (sel[IDX_CNT_HI]) rd_mux = hi_snap;
    if (sel[IDX_CTRL])   rd_mux = ctrl_view;
    if (sel[IDX_STAT])   rd_mux = {{(DATA_W-1){1'b0}}, flag};
    if (sel[IDX_CMP_LO]) rd_mux = cmp_val[DATA_W-1:0];
    if (sel[IDX_CMP_HI]) rd_mux = cmp_val[CNT_W-1:DATA_W];
    if (sel[IDX_STEP])   rd_mux = step_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      hi_snap <= '0;
    end else if (bus_rd) begin
      rd_data <= rd_mux;
      if (sel[IDX_CNT_LO]) hi_snap <= count[CNT_W-1:DATA_W];
    end
  end

  assign irq_out = flag && ie_q;

  // R5
  lo_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && aligned && word == WORD_W'(IDX_CNT_LO))
    |=> rd_data == $past(count[DATA_W-1:0]));

  // R5
  hi_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && aligned && word == WORD_W'(IDX_CNT_HI))
    |=> rd_data == $past(hi_snap));
endmodule

// File: tb/test_gtimer64.sv
module test_gtimer64;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  bus_addr;
  logic        bus_we;
  logic        bus_rd;
  logic [31:0] bus_wdata;
  logic [31:0] rd_data;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit pend = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  gtimer64 i_gtimer64 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  // driver: issues a read and pushes the expected word to the scoreboard
  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq_out !== e) begin
      errors++;
      $display("FAIL %s irq_out actual %0b expected %0b", t, irq_out, e);
    end
  endtask

  // monitor: read data appears one edge after the strobe
  always @(posedge clk) pend <= bus_rd;
  always @(negedge clk) begin
    if (pend) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        errors++;
        $display("FAIL %s rd_data actual %h expected %h", t, rd_data, e);
      end
    end
  end

  initial begin
    rst = 1'b1; bus_addr = '0; bus_we = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(5'h00, 32'h0, "R1 cnt lo");
    rd(5'h04, 32'h0, "R1 cnt hi");
    rd(5'h08, 32'h0, "R1 ctrl");
    rd(5'h0C, 32'h0, "R1 stat");
    rd(5'h10, 32'h0, "R1 cmp lo");

    // R2 divider 0: enabled edges 1..10 -> 10 increments
    wr(5'h08, 32'h1);
    repeat (9) @(negedge clk);
    wr(5'h08, 32'h0);
    rd(5'h00, 32'd10, "R2 div0");
    // R3 halted count is held, not cleared
    repeat (10) @(negedge clk);
    rd(5'h00, 32'd10, "R3 hold");

    // R2 divider 3: edges 1..20, every 4th -> 5
    wr(5'h00, 32'h0);
    wr(5'h08, 32'h0301);
    repeat (19) @(negedge clk);
    wr(5'h08, 32'h0);
    rd(5'h00, 32'd5, "R2 div3");
    rd(5'h04, 32'd0, "R2 div3 hi");

    // R4 load and carry into high word
    wr(5'h00, 32'hFFFF_FFFF);
    wr(5'h04, 32'h1);
    wr(5'h08, 32'h1);
    wr(5'h08, 32'h0);
    rd(5'h00, 32'h0, "R4 carry lo");
    rd(5'h04, 32'h2, "R4 carry hi");

    // R5 captured high word
    wr(5'h00, 32'h1234_5678);
    wr(5'h04, 32'h3);
    rd(5'h00, 32'h1234_5678, "R5 lo");
    wr(5'h04, 32'h9);
    rd(5'h04, 32'h3, "R5 snapshot");
    rd(5'h00, 32'h1234_5678, "R5 lo again");
    rd(5'h04, 32'h9, "R5 fresh hi");

    // R6 match sets flag (count is 9_12345678)
    wr(5'h10, 32'h1234_5678);
    wr(5'h14, 32'h9);
    wr(5'h08, 32'h2);
    @(negedge clk);
    rd(5'h0C, 32'h1, "R6 match");
    // R6 comparator disabled: no set after clear
    wr(5'h08, 32'h0);
    wr(5'h0C, 32'h1);
    @(negedge clk);
    rd(5'h0C, 32'h0, "R6 disabled");
    // R6 high word differs
    wr(5'h14, 32'h8);
    wr(5'h08, 32'h2);
    repeat (2) @(negedge clk);
    rd(5'h0C, 32'h0, "R6 no match");

    // R8 set wins over clear, write 0 ignored, write 1 clears
    wr(5'h14, 32'h9);
    @(negedge clk);
    rd(5'h0C, 32'h1, "R8 set");
    wr(5'h0C, 32'h1);
    @(negedge clk);
    rd(5'h0C, 32'h1, "R8 set wins");
    wr(5'h08, 32'h0);
    wr(5'h0C, 32'h0);
    rd(5'h0C, 32'h1, "R8 write0");
    wr(5'h0C, 32'h1);
    rd(5'h0C, 32'h0, "R8 clear");

    // R9 irq is flag AND enable
    wr(5'h08, 32'h6);
    chk_irq(1'b0, "R9 flag not yet set");
    @(negedge clk);
    chk_irq(1'b1, "R9 flag and enable");
    wr(5'h08, 32'h2);
    chk_irq(1'b0, "R9 enable off");
    wr(5'h08, 32'h0);
    wr(5'h0C, 32'h1);
    wr(5'h08, 32'h4);
    chk_irq(1'b0, "R9 flag clear");

    // R7 auto step
    wr(5'h08, 32'h0);
    wr(5'h0C, 32'h1);
    wr(5'h00, 32'd10);
    wr(5'h04, 32'h0);
    wr(5'h10, 32'd10);
    wr(5'h14, 32'h0);
    wr(5'h18, 32'd7);
    wr(5'h08, 32'hA);
    @(negedge clk);
    rd(5'h10, 32'd17, "R7 cmp lo");
    rd(5'h14, 32'h0, "R7 cmp hi");
    rd(5'h0C, 32'h1, "R7 flag");
    rd(5'h18, 32'd7, "R7 step");

    // R10 control view and unmapped / misaligned access
    wr(5'h08, 32'h0);
    wr(5'h08, 32'hABCD_5A0C);
    rd(5'h08, 32'h0000_5A0C, "R10 ctrl view");
    rd(5'h1C, 32'h0, "R10 unmapped");
    wr(5'h12, 32'hDEAD_BEEF);
    rd(5'h10, 32'd17, "R10 misaligned write");
    rd(5'h11, 32'h0, "R10 misaligned read");
    wr(5'h08, 32'h0);

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R5 pending reads actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule